// File: doc/BRIEF.md
# Accumulator-File Byte ALU

This block is the 8-bit execution datapath of a small accumulator-plus-register-file controller. Each cycle in which `in_valid` is high it takes a decoded operation code, a direction bit, the working register value, the file-register operand and the current carry. It produces a result byte, a write strobe that targets either the working register or the file register, and updated carry, digit-carry and zero flags. The three flags are held in registers inside the block. Signed and unsigned 8x8 multiplies return a 16-bit product. The low byte of the product appears on `result` and the high byte on `prod_hi`.

All outputs are registered on one rising clock edge, so a result appears one cycle after its operands. The surrounding core handles instruction fetch, raw-opcode decode, register storage and paired-register arithmetic. That core uses `wr_w` and `wr_f` to route `result`, and it reads the flags back from `c_flag`, `dc_flag` and `z_flag`.

Top module: `byteacc_alu`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 invert, 10 nibble swap, 11 rotate left, 12 rotate right, 13 move, 14 test, 15 clear, 16 compare, 17 unsigned multiply and 18 signed multiply. For every writing operation except multiply, `dir`=1 pulses `wr_w` and `dir`=0 pulses `wr_f`, one cycle after the valid input. The two strobes are never high together, and `out_valid` follows `in_valid` by one cycle.
- R2: Add gives (W+F) mod 256, and add-with-carry adds `c_in` as well. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result byte is zero.
- R3: Subtract gives (F−W) mod 256. Subtract-with-carry gives (F−W−(1−c_in)) mod 256. C is 1 when no borrow leaves bit 7 and DC is 1 when no borrow leaves bit 3; Z is set from the result.
- R4: Compare evaluates W−F only to set flags: C=(W≥F), DC=(W[3:0]≥F[3:0]) and Z=(W==F). Neither strobe is raised.
- R5: Increment gives (F+1) mod 256 and decrement gives (F−1) mod 256. Only Z changes, and C and DC keep their previous values.
- R6: AND gives W&F, OR gives W|F, XOR gives W^F, invert gives ~F and clear gives 0. Each updates only Z, from its result.
- R7: Move with `dir`=1 delivers F to W, and with `dir`=0 delivers W to F; Z is set from the moved byte. Test raises no strobe and sets Z from F alone.
- R8: Nibble swap delivers {F[3:0],F[7:4]} and changes no flag.
- R9: Rotate left delivers {F[6:0],c_in} and sets C to F[7]. Rotate right delivers {c_in,F[7:1]} and sets C to F[0]. DC and Z are unchanged.
- R10: Unsigned multiply forms the zero-extended 16-bit product W×F, and signed multiply forms the two's-complement product of the sign-extended operands. The low byte goes to `result` with `wr_w` pulsed regardless of `dir`, and the high byte goes to `prod_hi`. No flag changes. `prod_hi` changes only on a multiply.
- R11: A cycle with `in_valid` low, or with an operation code from 19 to 31, raises no strobe and changes no flag and no `prod_hi`. An idle cycle also leaves `out_valid` low.
- R12: A synchronous active-high reset clears all flags, strobes, `out_valid`, `result` and `prod_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op | input | 5 | Operation code (see R1) |
| dir | input | 1 | Destination: 1 = working register, 0 = file register |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File-register operand |
| c_in | input | 1 | Current carry used by carry-chained and rotate operations |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 8 | Result byte (product low byte on multiply) |
| prod_hi | output | 8 | High byte of the most recent product |
| wr_w | output | 1 | Write result to the working register |
| wr_f | output | 1 | Write result to the file register |
| c_flag | output | 1 | Carry / not-borrow flag |
| dc_flag | output | 1 | Digit carry / not-borrow from bit 3 |
| z_flag | output | 1 | Zero flag |

## Verification
The hardest conditions to reach are the nibble-boundary digit-carry and borrow cases, especially in subtract-with-carry. There the incoming carry decides whether a borrow ripples out of bit 3 or bit 7 when the nibbles or bytes are equal. The bench sweeps every operation code, both directions and both carry inputs over an operand grid. The grid is multiples of 15 plus 0x7F, 0x80 and 0x08, which places equal nibbles, 0x0F/0x10 crossings and sign boundaries on both operands. Idle cycles are inserted after each operation block to show that held flags survive.

// File: rtl/byteacc_pkg.sv
package byteacc_pkg;

    localparam int DW = 8;
    localparam int HW = DW / 2;
    localparam int PW = 2 * DW;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
        OP_INC  = 5'd4,  OP_DEC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_SWAP = 5'd10, OP_RL   = 5'd11,
        OP_RR   = 5'd12, OP_MOV  = 5'd13, OP_TEST = 5'd14, OP_CLR  = 5'd15,
        OP_CMP  = 5'd16, OP_MULU = 5'd17, OP_MULS = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          co;
        logic          hc;
    } sum_t;

    typedef struct packed {
        logic writes;
        logic upd_c;
        logic upd_dc;
        logic upd_z;
        logic w_only;
    } ctl_t;

    function automatic sum_t add3(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic cin);
        logic [HW:0] lo;
        logic [HW:0] hi;
        sum_t s;
        lo = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        hi = {1'b0, a[DW-1:HW]} + {1'b0, b[DW-1:HW]} + {{HW{1'b0}}, lo[HW]};
        s.val = {hi[HW-1:0], lo[HW-1:0]};
        s.co  = hi[HW];
        s.hc  = lo[HW];
        return s;
    endfunction

    function automatic ctl_t op_ctl(input alu_op_e op);
        ctl_t c;
        c = '0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR, OP_MOV:
                c = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            OP_SWAP:          c = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            OP_RL, OP_RR:     c = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            OP_TEST:          c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            OP_CMP:           c = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            OP_MULU, OP_MULS: c = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
            default:          c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/byteacc_addsub.sv
module byteacc_addsub
    import byteacc_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    input  logic          cin,
    output sum_t          s
);
    logic [DW-1:0] a, b;
    logic          ci;

    // Subtraction is done as a + ~b + 1 (or + carry), so the carry out is the not-borrow.
    always_comb begin
        a  = f;
        b  = '0;
        ci = 1'b0;
        case (op)
            OP_ADD:  begin a = w; b = f;  ci = 1'b0; end
            OP_ADDC: begin a = w; b = f;  ci = cin;  end
            OP_SUB:  begin a = f; b = ~w; ci = 1'b1; end
            OP_SUBC: begin a = f; b = ~w; ci = cin;  end
            OP_INC:  begin a = f; b = '0; ci = 1'b1; end
            OP_DEC:  begin a = f; b = '1; ci = 1'b0; end
            OP_CMP:  begin a = w; b = ~f; ci = 1'b1; end
            default: begin a = f; b = '0; ci = 1'b0; end
        endcase
        s = add3(a, b, ci);
    end
endmodule

// File: rtl/byteacc_bitops.sv
module byteacc_bitops
    import byteacc_pkg::*;
(
    input  alu_op_e       op,
    input  logic          dir,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          rot_c
);
    always_comb begin
        case (op)
            OP_AND:  res = w & f;
            OP_OR:   res = w | f;
            OP_XOR:  res = w ^ f;
            OP_NOT:  res = ~f;
            OP_SWAP: res = {f[HW-1:0], f[DW-1:HW]};
            OP_RL:   res = {f[DW-2:0], cin};
            OP_RR:   res = {cin, f[DW-1:1]};
            OP_MOV:  res = dir ? f : w;
            OP_CLR:  res = '0;
            default: res = f;
        endcase
        rot_c = (op == OP_RL) ? f[DW-1] : f[0];
    end
endmodule

// File: rtl/byteacc_mul.sv
module byteacc_mul
    import byteacc_pkg::*;
(
    input  logic          is_signed,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] f,
    output logic [PW-1:0] prod
);
    logic signed [PW-1:0] sp;
    logic        [PW-1:0] up;

    always_comb begin
        sp   = PW'($signed(w)) * PW'($signed(f));
        up   = {{DW{1'b0}}, w} * {{DW{1'b0}}, f};
        prod = is_signed ? $unsigned(sp) : up;
    end
endmodule

// File: rtl/byteacc_alu.sv
module byteacc_alu
    import byteacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [4:0]    op,
    input  logic          dir,
    input  logic [DW-1:0] w_in,
    input  logic [DW-1:0] f_in,
    input  logic          c_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [DW-1:0] prod_hi,
    output logic          wr_w,
    output logic          wr_f,
    output logic          c_flag,
    output logic          dc_flag,
    output logic          z_flag
);
    alu_op_e       op_e;
    ctl_t          ctl;
    sum_t          arith;
    logic [DW-1:0] bits_res;
    logic          rot_c;
    logic [PW-1:0] prod;
    logic          is_mul;
    logic [DW-1:0] res_n;
    logic          c_n, dc_n, z_n;

    assign op_e   = alu_op_e'(op);
    assign ctl    = op_ctl(op_e);
    assign is_mul = (op_e == OP_MULU) || (op_e == OP_MULS);

    byteacc_addsub u_addsub (.op(op_e), .w(w_in), .f(f_in), .cin(c_in), .s(arith));
    byteacc_bitops u_bitops (.op(op_e), .dir(dir), .w(w_in), .f(f_in), .cin(c_in),
                             .res(bits_res), .rot_c(rot_c));
    byteacc_mul    u_mul    (.is_signed(op_e == OP_MULS), .w(w_in), .f(f_in), .prod(prod));

    always_comb begin
        case (op_e)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_INC, OP_DEC, OP_CMP: res_n = arith.val;
            OP_MULU, OP_MULS: res_n = prod[DW-1:0];
            default:          res_n = bits_res;
        endcase
        c_n  = c_flag;
        dc_n = dc_flag;
        z_n  = z_flag;
        if (ctl.upd_c)  c_n  = (op_e == OP_RL || op_e == OP_RR) ? rot_c : arith.co;
        if (ctl.upd_dc) dc_n = arith.hc;
        if (ctl.upd_z)  z_n  = (res_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            prod_hi   <= '0;
            wr_w      <= 1'b0;
            wr_f      <= 1'b0;
            c_flag    <= 1'b0;
            dc_flag   <= 1'b0;
            z_flag    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_w      <= in_valid && ctl.writes && (dir || ctl.w_only);
            wr_f      <= in_valid && ctl.writes && !dir && !ctl.w_only;
            if (in_valid) begin
                result  <= res_n;
                c_flag  <= c_n;
                dc_flag <= dc_n;
                z_flag  <= z_n;
                if (is_mul) prod_hi <= prod[PW-1:DW];
            end
        end
    end

    assert_single_target_R1: assert property (@(posedge clk) disable iff (rst)
        !(wr_w && wr_f));

    assert_compare_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd16) |=> (!wr_w && !wr_f));

    assert_count_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 5'd4 || op == 5'd5)) |=> (c_flag == $past(c_flag) && dc_flag == $past(dc_flag)));

    assert_swap_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd10) |=> $stable({c_flag, dc_flag, z_flag}));

    assert_mul_to_w_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 5'd17 || op == 5'd18)) |=> (wr_w && !wr_f));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_w && !wr_f && $stable({c_flag, dc_flag, z_flag, prod_hi})));
endmodule

// File: tb/byteacc_alu_test.sv
`timescale 1ns/1ps
module byteacc_alu_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [4:0] op;
    logic       dir;
    logic [7:0] w_in, f_in;
    logic       c_in;
    logic       out_valid, wr_w, wr_f, c_flag, dc_flag, z_flag;
    logic [7:0] result, prod_hi;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  ec = 0, edc = 0, ez = 0, ehi = 0;

    always #10 clk = ~clk;

    byteacc_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dir(dir),
        .w_in(w_in), .f_in(f_in), .c_in(c_in), .out_valid(out_valid),
        .result(result), .prod_hi(prod_hi), .wr_w(wr_w), .wr_f(wr_f),
        .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1:    return "R2";
            2, 3:    return "R3";
            16:      return "R4";
            4, 5:    return "R5";
            6, 7, 8, 9, 15: return "R6";
            13, 14:  return "R7";
            10:      return "R8";
            11, 12:  return "R9";
            17, 18:  return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int grid(input int i);
        if (i < 18) return i * 15;
        if (i == 18) return 127;
        if (i == 19) return 128;
        return 8;
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic compare(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge, then check at the next falling edge.
    task automatic run_vec(input int o, input int d, input int w, input int f, input int ci);
        int r = 0, ww = 0, wf = 0, wrt = 1, bin, p;
        in_valid = 1'b1; op = 5'(o); dir = d[0]; w_in = 8'(w); f_in = 8'(f); c_in = ci[0];
        case (o)
            0, 1: begin
                r = w + f + ((o == 1) ? ci : 0);
                edc = ((w % 16) + (f % 16) + ((o == 1) ? ci : 0)) >= 16;
                ec = r >= 256; r = r % 256; ez = (r == 0);
            end
            2, 3: begin
                bin = (o == 3) ? 1 - ci : 0;
                ec = f >= w + bin; edc = (f % 16) >= (w % 16) + bin;
                r = (f - w - bin + 512) % 256; ez = (r == 0);
            end
            4: begin r = (f + 1) % 256; ez = (r == 0); end
            5: begin r = (f + 255) % 256; ez = (r == 0); end
            6: begin r = w & f; ez = (r == 0); end
            7: begin r = w | f; ez = (r == 0); end
            8: begin r = w ^ f; ez = (r == 0); end
            9: begin r = 255 - f; ez = (r == 0); end
            10: r = (f % 16) * 16 + f / 16;
            11: begin r = (f * 2) % 256 + ci; ec = f / 128; end
            12: begin r = ci * 128 + f / 2; ec = f % 2; end
            13: begin r = d ? f : w; ez = (r == 0); end
            14: begin wrt = 0; ez = (f == 0); end
            15: begin r = 0; ez = 1; end
            16: begin
                wrt = 0; ec = w >= f; edc = (w % 16) >= (f % 16); ez = (w == f);
            end
            17, 18: begin
                p = (o == 17) ? w * f : sx(w) * sx(f);
                p = p & 16'hFFFF; r = p % 256; ehi = p / 256;
            end
            default: wrt = 0;
        endcase
        if (wrt != 0) begin
            if (o == 17 || o == 18 || d != 0) ww = 1; else wf = 1;
        end
        @(negedge clk);
        // R1: strobe routing and valid timing; flags/prod_hi per the operation's requirement
        compare("R1", {out_valid, wr_w, wr_f}, {1'b1, ww[0], wf[0]});
        compare(tag_of(o), {c_flag, dc_flag, z_flag, prod_hi},
                {ec[0], edc[0], ez[0], ehi[7:0]});
        if (wrt != 0) compare(tag_of(o), result, r);
    endtask

    task automatic idle_vec();
        in_valid = 1'b0; op = 5'd0; w_in = 8'hFF; f_in = 8'hFF; c_in = 1'b1;
        @(negedge clk);
        compare("R11", {out_valid, wr_w, wr_f, c_flag, dc_flag, z_flag, prod_hi},
                {3'b000, ec[0], edc[0], ez[0], ehi[7:0]});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; dir = 1'b0; w_in = '0; f_in = '0; c_in = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        compare("R12", {out_valid, wr_w, wr_f, c_flag, dc_flag, z_flag, result, prod_hi}, 0);
        rst = 1'b0;
        for (int o = 0; o < 32; o++) begin
            for (int d = 0; d < 2; d++)
                for (int ci = 0; ci < 2; ci++)
                    for (int i = 0; i < 21; i++)
                        for (int j = 0; j < 21; j++)
                            run_vec(o, d, grid(i), grid(j), ci);
            idle_vec();
        end
        // R12: reset mid-run clears flags and product
        run_vec(18, 0, 128, 127, 0);
        run_vec(0, 1, 255, 1, 0);
        rst = 1'b1; @(negedge clk);
        compare("R12", {out_valid, wr_w, wr_f, c_flag, dc_flag, z_flag, result, prod_hi}, 0);
        rst = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule